// File: doc/BRIEF.md
# Transmit Deferral Watchdog Timer

In a half-duplex MAC a transmitter that has a frame ready must hold off while carrier sense shows the medium busy. This block measures that hold-off in bit times. When an optional check is on and the hold-off runs too long, it cancels the attempt with a one-cycle abort pulse. The count covers a single wait only. It restarts from zero whenever the wait ends: carrier drops, the transmitter stops being ready, or a backoff completes or a transmission starts. Time spent in earlier waits is never added to the current one.

The MAC supplies a bit-time strobe, the ready flag, carrier sense, a restart strobe and the check-enable control bit. It receives a deferring status and the abort pulse. After an abort the block stays quiet until the transmitter withdraws its ready flag, so each attempt is cancelled at most once.

Top module: `defer_watchdog`

## Requirements
- R1: `deferring_o` is high exactly when `tx_ready_i` and `crs_i` are both high, unless the block is locked out after an abort (R5). After reset `abort_o` is low and no lockout is active.
- R2: While deferring, the wait count rises by one on each clock edge with `bit_tick_i` high. Edges without a tick leave it unchanged. Ticks while not deferring add nothing.
- R3: With `chk_en_i` high, `abort_o` is high in the cycle after the edge that carries the (LIMIT+1)-th tick of one continuous wait. LIMIT defaults to 24288. After LIMIT ticks there has been no abort.
- R4: `abort_o` never stays high for two cycles in a row.
- R5: After an abort, `deferring_o` stays low and no further abort occurs until `tx_ready_i` has been low for at least one clock edge.
- R6: If `crs_i` falls before the limit, the wait ends with no abort. A later wait counts again from zero.
- R7: A clock edge with `restart_i` high clears the wait count, so the wait that follows counts from zero.
- R8: With `chk_en_i` low, no abort is issued however long the wait lasts, and `deferring_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_en_i | input | 1 | Enables the excessive-wait abort |
| tx_ready_i | input | 1 | Transmitter has a frame ready |
| crs_i | input | 1 | Carrier sense, medium busy |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| restart_i | input | 1 | Backoff done or transmit start; clears the count |
| abort_o | output | 1 | One-cycle excessive-wait abort |
| deferring_o | output | 1 | Transmitter is held off by carrier |

## Verification
The assertions check four properties on every cycle:
- the abort lasts one cycle;
- an abort never comes without an enabled check and a ready, blocked transmitter;
- an abort is always preceded by a count at the limit;
- after an abort the deferring status is low, and the count is zero after any cycle without deferral.

Only the bench scenarios can show the exact tick on which the abort lands. The same applies to the gaps without ticks that must not count, to a new wait after carrier loss or restart counting from zero, and to a disabled check that tolerates a wait past the limit.

// File: rtl/defer_watchdog_pkg.sv
package defer_watchdog_pkg;
  localparam int unsigned DFR_LIMIT_DEF = 24288;

  function automatic int unsigned dfr_cnt_w(input int unsigned lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/defer_counter.sv
module defer_counter #(
  parameter int unsigned LIMIT = 24288,
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_lim_o
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != LIM_C)  cnt_q <= cnt_q + CNT_W'(1); // saturate at limit
  end

  assign cnt_o    = cnt_q;
  assign at_lim_o = (cnt_q == LIM_C);
endmodule

// File: rtl/defer_abort_ctrl.sv
module defer_abort_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_en_i,
  input  logic tx_ready_i,
  input  logic crs_i,
  input  logic bit_tick_i,
  input  logic at_lim_i,
  output logic deferring_o,
  output logic fire_o,
  output logic abort_o
);
  logic lock_q, abort_q;

  assign deferring_o = tx_ready_i & crs_i & ~lock_q;
  // tick that would take the count past the limit
  assign fire_o = deferring_o & chk_en_i & bit_tick_i & at_lim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= fire_o;
      if (fire_o)           lock_q <= 1'b1;
      else if (!tx_ready_i) lock_q <= 1'b0;
    end
  end

  assign abort_o = abort_q;
endmodule

// File: rtl/defer_watchdog.sv
module defer_watchdog
  import defer_watchdog_pkg::*;
#(
  parameter int unsigned LIMIT = DFR_LIMIT_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_en_i,
  input  logic tx_ready_i,
  input  logic crs_i,
  input  logic bit_tick_i,
  input  logic restart_i,
  output logic abort_o,
  output logic deferring_o
);
  localparam int unsigned CNT_W = dfr_cnt_w(LIMIT);

  logic [CNT_W-1:0] cnt;
  logic at_lim, fire, dfr;

  defer_abort_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chk_en_i   (chk_en_i),
    .tx_ready_i (tx_ready_i),
    .crs_i      (crs_i),
    .bit_tick_i (bit_tick_i),
    .at_lim_i   (at_lim),
    .deferring_o(dfr),
    .fire_o     (fire),
    .abort_o    (abort_o)
  );

  defer_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~dfr | restart_i | fire),
    .inc_i   (bit_tick_i),
    .cnt_o   (cnt),
    .at_lim_o(at_lim)
  );

  assign deferring_o = dfr;
endmodule

// File: rtl/defer_watchdog_chk.sv
module defer_watchdog_chk #(
  parameter int unsigned LIMIT = 24288,
  parameter int unsigned CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chk_en_i,
  input logic             tx_ready_i,
  input logic             crs_i,
  input logic             abort_o,
  input logic             deferring_o,
  input logic [CNT_W-1:0] cnt_i
);
  p_abort_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  p_abort_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(chk_en_i && tx_ready_i && crs_i));

  p_abort_at_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(cnt_i == CNT_W'(LIMIT)));

  p_locked_after_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !deferring_o);

  p_idle_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deferring_o |=> (cnt_i == '0));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(LIMIT));
endmodule

bind defer_watchdog defer_watchdog_chk #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chk_en_i   (chk_en_i),
  .tx_ready_i (tx_ready_i),
  .crs_i      (crs_i),
  .abort_o    (abort_o),
  .deferring_o(deferring_o),
  .cnt_i      (cnt)
);

// File: tb/defer_watchdog_tb_top.sv
`timescale 1ns/1ps
module defer_watchdog_tb_top;
  localparam int LIM = 24288;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chk_en = 1'b0, tx_ready = 1'b0, crs = 1'b0, tick = 1'b0, restart = 1'b0;
  logic abort, deferring;
  int total = 0, bad = 0, aborts = 0, cyc = 0;

  always #2.5 clk = ~clk;

  defer_watchdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chk_en_i(chk_en), .tx_ready_i(tx_ready),
    .crs_i(crs), .bit_tick_i(tick), .restart_i(restart),
    .abort_o(abort), .deferring_o(deferring)
  );

  always @(negedge clk) begin
    cyc++;
    if (abort) aborts++;
  end

  // {tx_ready, crs, chk_en, expected deferring}
  localparam logic [3:0] VEC [6] = '{4'b0000, 4'b1000, 4'b0100, 4'b1101, 4'b1111, 4'b0110};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_wait();
    @(negedge clk) begin tx_ready = 1'b0; crs = 1'b0; end
    idle(2);
    aborts = 0;
  endtask

  initial begin
    #1;
    check("R1 reset abort", abort, 0);
    check("R1 reset deferring", deferring, 0);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 table walk
    foreach (VEC[i]) begin
      @(negedge clk) {tx_ready, crs, chk_en} = VEC[i][3:1];
      #1;
      check("R1 deferring", deferring, int'(VEC[i][0]));
      check("R1 no abort", abort, 0);
    end
    end_wait();

    // R3/R2/R4/R5: exact tick, tick gaps ignored
    chk_en = 1'b1;
    @(negedge clk) begin tx_ready = 1'b1; crs = 1'b1; end
    ticks(LIM);
    idle(100);
    check("R3 none at limit", aborts, 0);
    check("R2 still deferring", deferring, 1);
    ticks(1);
    check("R3 abort on next tick", abort, 1);
    idle(1);
    check("R4 abort one cycle", abort, 0);
    check("R5 deferring locked", deferring, 0);
    ticks(30);
    check("R5 single abort", aborts, 1);
    @(negedge clk) tx_ready = 1'b0;
    @(negedge clk) tx_ready = 1'b1;
    #1;
    check("R5 relock cleared", deferring, 1);
    end_wait();

    // R6: carrier drop restarts; ticks without carrier ignored (R2)
    @(negedge clk) begin tx_ready = 1'b1; crs = 1'b1; end
    ticks(LIM);
    @(negedge clk) crs = 1'b0;
    ticks(50);
    @(negedge clk) crs = 1'b1;
    ticks(LIM);
    check("R6 not cumulative", aborts, 0);
    ticks(1);
    check("R6 abort after fresh wait", abort, 1);
    end_wait();

    // R7: restart clears count
    @(negedge clk) begin tx_ready = 1'b1; crs = 1'b1; end
    ticks(LIM);
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    ticks(LIM);
    check("R7 restart clears", aborts, 0);
    ticks(1);
    check("R7 abort after restart", abort, 1);
    end_wait();

    // R8: disabled check
    chk_en = 1'b0;
    @(negedge clk) begin tx_ready = 1'b1; crs = 1'b1; end
    ticks(LIM + 50);
    check("R8 no abort disabled", aborts, 0);
    check("R8 still deferring", deferring, 1);
    end_wait();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule